// File: doc/BRIEF.md
# UART RTS/CTS Handshake Controller

This block sits beside a UART's receive FIFO and transmit shifter and runs the two hardware handshake lines. On the receive side it watches how full the receive FIFO is and drops its request-to-send line once a programmable fill level is reached, so the far end stops sending. It raises the line again only after the FIFO has drained to half that level. On the transmit side it samples the far end's clear-to-send line through a two-stage synchronizer. It grants permission to start a character only at character boundaries, so a character already in flight always completes.

Each line has its own enable and its own polarity inversion. The control inputs are meant to be wired from a control word: RTS enable from bit 18, the RTS fill-level code from bits 20:19, RTS inversion from bit 21, CTS enable from bit 14 and CTS inversion from bit 15. The FIFOs, the shifters and the register file are outside the block.

Top module: `uart_flow_ctl`

## Requirements
- R1: While reset is held and afterwards, RTS stays deasserted until `rts_en` has been seen high at least once. Deasserted is pin high when `rts_inv` is 0.
- R2: The fill threshold code `rts_lvl` selects 8 bytes for code 0, 16 bytes for code 1, 32 bytes for code 2 and 48 bytes for code 3.
- R3: With `rts_en` high, RTS deasserts one clock after `rx_count` is at or above the selected threshold.
- R4: With `rts_en` high, RTS reasserts one clock after `rx_count` is at or below half the threshold. Between half and the full threshold, RTS keeps its previous level.
- R5: Once RTS has been enabled, clearing `rts_en` holds RTS asserted whatever the FIFO count.
- R6: With `rts_inv` at 0, asserted RTS drives `rts_pin` low. With `rts_inv` at 1, every RTS level appears inverted on the pin.
- R7: With `cts_en` low, `tx_permit` is high on every cycle.
- R8: With `cts_inv` at 0, CTS is asserted when `cts_pin` is low. With `cts_inv` at 1, CTS is asserted when the pin is high.
- R9: A change on `cts_pin` reaches `tx_permit` after exactly two rising clock edges.
- R10: With `cts_en` high, `tx_permit` follows the synchronized CTS only while `tx_ready` is high. While `tx_ready` is low, it keeps the value it had in the last cycle before `tx_ready` fell.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_count | input | CNT_W | Current receive FIFO fill count in bytes |
| cts_pin | input | 1 | Raw clear-to-send line from the far end |
| tx_ready | input | 1 | High while the transmitter sits between characters and may start the next one |
| rts_en | input | 1 | RTS automatic control enable (control word bit 18) |
| rts_lvl | input | 2 | RTS fill threshold code (control word bits 20:19) |
| rts_inv | input | 1 | RTS pin polarity inversion (control word bit 21) |
| cts_en | input | 1 | CTS gating enable (control word bit 14) |
| cts_inv | input | 1 | CTS sense polarity inversion (control word bit 15) |
| rts_pin | output | 1 | Request-to-send line to the far end |
| tx_permit | output | 1 | Permission for the transmitter to start the next character |

## Verification
The checker watches the threshold rules on every cycle. Whenever the previous count was at or above the threshold, RTS must be deasserted. Whenever it was at or below half the threshold, RTS must be asserted. In the band between the two, RTS must not change. The checker also confirms that `tx_permit` is high whenever CTS gating is off and that it holds steady while `tx_ready` is low. Some behaviours only the directed scenarios can show: the reset level kept until the first enable, the exact two-edge synchronizer latency, the per-code threshold values, and the pin levels under each inversion bit.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
  localparam int LVL_W = 2;
  localparam int THR_W = 6;

  // Fill threshold in bytes for a two-bit level code.
  function automatic logic [THR_W-1:0] lvl_to_bytes(input logic [LVL_W-1:0] code);
    logic [THR_W-1:0] r;
    case (code)
      2'd0:    r = 6'd8;
      2'd1:    r = 6'd16;
      2'd2:    r = 6'd32;
      default: r = 6'd48;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fc_cts_sync.sv
module fc_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic inv,
  output logic cts_ok
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
  end

  // Reset to the idle, not-clear level (pin high).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  // Non-inverted: a low pin means clear to send.
  assign cts_ok = ~sync_q[STAGES-1] ^ inv;
endmodule

// File: rtl/fc_rts_hyst.sv
module fc_rts_hyst
  import flowctl_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LVL_W-1:0] lvl,
  input  logic [CNT_W-1:0] rx_count,
  output logic             active
);
  logic             armed_q, armed_d;
  logic             act_q, act_d;
  logic [THR_W-1:0] thr;
  logic [THR_W-1:0] half;
  logic             at_full, at_half;

  always_comb begin
    thr     = lvl_to_bytes(lvl);
    half    = thr >> 1;
    at_full = int'(rx_count) >= int'(thr);
    at_half = int'(rx_count) <= int'(half);
    armed_d = armed_q | en;
    act_d   = act_q;
    if (!armed_d)     act_d = 1'b0;
    else if (!en)     act_d = 1'b1;
    else if (at_full) act_d = 1'b0;
    else if (at_half) act_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      if (en) armed_q <= armed_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cts_ok,
  input  logic tx_ready,
  output logic tx_permit
);
  logic held_q;
  logic cur;

  always_comb begin
    cur = tx_ready ? cts_ok : held_q;
  end

  // The decision is only refreshed while the transmitter is between characters.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held_q <= 1'b0;
    else if (tx_ready) held_q <= cur;
  end

  assign tx_permit = en ? cur : 1'b1;
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
  import flowctl_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             cts_pin,
  input  logic             tx_ready,
  input  logic             rts_en,
  input  logic [LVL_W-1:0] rts_lvl,
  input  logic             rts_inv,
  input  logic             cts_en,
  input  logic             cts_inv,
  output logic             rts_pin,
  output logic             tx_permit
);
  logic rts_active;
  logic cts_ok;

  fc_rts_hyst #(.CNT_W(CNT_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .en(rts_en), .lvl(rts_lvl),
    .rx_count(rx_count), .active(rts_active)
  );

  fc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(cts_pin), .inv(cts_inv), .cts_ok(cts_ok)
  );

  fc_tx_gate u_gate (
    .clk(clk), .rst_n(rst_n), .en(cts_en), .cts_ok(cts_ok),
    .tx_ready(tx_ready), .tx_permit(tx_permit)
  );

  // Non-inverted: asserted request drives the pin low.
  assign rts_pin = ~rts_active ^ rts_inv;
endmodule

// File: rtl/flow_ctl_chk.sv
module flow_ctl_chk
  import flowctl_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] rx_count,
  input logic             tx_ready,
  input logic             rts_en,
  input logic [LVL_W-1:0] rts_lvl,
  input logic             rts_inv,
  input logic             cts_en,
  input logic             rts_pin,
  input logic             tx_permit
);
  logic             act;
  logic [THR_W-1:0] thr;
  logic             full_c, half_c;

  always_comb begin
    act    = ~(rts_pin ^ rts_inv);
    thr    = lvl_to_bytes(rts_lvl);
    full_c = int'(rx_count) >= int'(thr);
    half_c = int'(rx_count) <= int'(thr >> 1);
  end

  assert_full_deasserts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rts_en) && $past(full_c)) |-> !act);

  assert_half_reasserts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rts_en) && $past(half_c)) |-> act);

  // R4: band between the two levels keeps the previous RTS level
  assert_band_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rts_en) && !$past(full_c) && !$past(half_c))
      |-> act == $past(act));

  assert_cts_off_permits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cts_en |-> tx_permit);

  assert_midchar_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cts_en) && cts_en && !tx_ready)
      |-> tx_permit == $past(tx_permit));
endmodule

bind uart_flow_ctl flow_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_ready(tx_ready),
  .rts_en(rts_en), .rts_lvl(rts_lvl), .rts_inv(rts_inv), .cts_en(cts_en),
  .rts_pin(rts_pin), .tx_permit(tx_permit)
);

// File: tb/sim_uart_flow_ctl.sv
`timescale 1ns/1ps
module sim_uart_flow_ctl;
  localparam int CNT_W = 7;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] rx_count;
  logic             cts_pin, tx_ready, rts_en, rts_inv, cts_en, cts_inv;
  logic [1:0]       rts_lvl;
  logic             rts_pin, tx_permit;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  uart_flow_ctl u0 (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .cts_pin(cts_pin),
    .tx_ready(tx_ready), .rts_en(rts_en), .rts_lvl(rts_lvl), .rts_inv(rts_inv),
    .cts_en(cts_en), .cts_inv(cts_inv), .rts_pin(rts_pin), .tx_permit(tx_permit)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int thr_of(input int code);
    case (code)
      0: return 8;
      1: return 16;
      2: return 32;
      default: return 48;
    endcase
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; rx_count = '0; cts_pin = 1'b1; tx_ready = 1'b0;
    rts_en = 1'b0; rts_lvl = 2'd0; rts_inv = 1'b0; cts_en = 1'b0; cts_inv = 1'b0;
    step(3);
    check(rts_pin, 1'b1, "R1 rts during reset");
    check(tx_permit, 1'b1, "R7 permit during reset");
    rst_n = 1'b1;
    step(3);
    check(rts_pin, 1'b1, "R1 rts never enabled");
    rx_count = 7'd60;
    step(2);
    check(rts_pin, 1'b1, "R1 rts never enabled, full fifo");
    rx_count = '0;
    step(1);
  endtask

  task automatic t_levels();
    for (int c = 0; c < 4; c++) begin
      int t;
      t = thr_of(c);
      rts_en = 1'b1; rts_lvl = c[1:0]; rx_count = '0;
      step(1);
      check(rts_pin, 1'b0, $sformatf("R2 code %0d empty asserted", c));
      rx_count = 7'(t - 1);
      step(1);
      check(rts_pin, 1'b0, $sformatf("R2 code %0d below threshold", c));
      rx_count = 7'(t);
      step(1);
      check(rts_pin, 1'b1, $sformatf("R3 code %0d at threshold", c));
      rx_count = 7'(t / 2 + 1);
      step(1);
      check(rts_pin, 1'b1, $sformatf("R4 code %0d band holds", c));
      rx_count = 7'(t / 2);
      step(1);
      check(rts_pin, 1'b0, $sformatf("R4 code %0d at half", c));
    end
  endtask

  task automatic t_rts_disable();
    rts_lvl = 2'd0; rx_count = 7'd60; rts_en = 1'b1;
    step(1);
    check(rts_pin, 1'b1, "R3 full before disable");
    rts_en = 1'b0;
    step(1);
    check(rts_pin, 1'b0, "R5 disabled holds asserted");
    step(2);
    check(rts_pin, 1'b0, "R5 still asserted");
    rx_count = '0;
  endtask

  task automatic t_rts_invert();
    rts_en = 1'b1; rts_inv = 1'b1; rts_lvl = 2'd1; rx_count = '0;
    step(1);
    check(rts_pin, 1'b1, "R6 inverted asserted");
    rx_count = 7'd16;
    step(1);
    check(rts_pin, 1'b0, "R6 inverted deasserted");
    rts_inv = 1'b0; rx_count = '0;
    step(1);
  endtask

  task automatic t_cts_off();
    cts_en = 1'b0; cts_pin = 1'b1; tx_ready = 1'b0;
    step(3);
    check(tx_permit, 1'b1, "R7 not clear, idle");
    tx_ready = 1'b1;
    step(1);
    check(tx_permit, 1'b1, "R7 not clear, ready");
  endtask

  task automatic t_cts_sync();
    cts_en = 1'b1; cts_inv = 1'b0; tx_ready = 1'b1; cts_pin = 1'b1;
    step(3);
    check(tx_permit, 1'b0, "R8 pin high blocks");
    cts_pin = 1'b0;
    step(1);
    check(tx_permit, 1'b0, "R9 one edge not yet");
    step(1);
    check(tx_permit, 1'b1, "R9 two edges through");
    cts_inv = 1'b1;
    #1;
    check(tx_permit, 1'b0, "R8 inverted pin low blocks");
    cts_pin = 1'b1;
    step(2);
    check(tx_permit, 1'b1, "R8 inverted pin high permits");
    cts_inv = 1'b0; cts_pin = 1'b0;
    step(2);
  endtask

  task automatic t_midchar();
    cts_en = 1'b1; cts_pin = 1'b0; tx_ready = 1'b1;
    step(3);
    check(tx_permit, 1'b1, "R10 permitted at boundary");
    tx_ready = 1'b0;
    step(1);
    cts_pin = 1'b1;
    step(3);
    check(tx_permit, 1'b1, "R10 held during character");
    tx_ready = 1'b1;
    #1;
    check(tx_permit, 1'b0, "R10 boundary sees cts drop");
    step(1);
    tx_ready = 1'b0;
    cts_pin = 1'b0;
    step(3);
    check(tx_permit, 1'b0, "R10 refusal held until boundary");
    tx_ready = 1'b1;
    #1;
    check(tx_permit, 1'b1, "R10 boundary sees cts return");
  endtask

  initial begin
    t_reset();
    t_levels();
    t_rts_disable();
    t_rts_invert();
    t_cts_off();
    t_cts_sync();
    t_midchar();
    step(2);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule